// File: doc/BRIEF.md
# Lockable Charger Limit Register File

This block holds the configuration registers of a battery charger, written over a plain address, data and write-strobe bus and read through a combinational read port. One register carries two safety ceilings: the largest charge-current code and the largest regulation-voltage code the charger may use. The two codes sent on to the charger are never allowed to go above these ceilings.

The ceiling register can only be set during a short window. It accepts writes until the first write to any parameter register, and then it locks. An external active-low limit-reset pin holds the ceilings at their lowest codes, drops any write to them and reopens the window. A self-clearing bit in the control register reloads every parameter register with its default value. This bit does not touch the ceilings or the lock.

The serial front end and the analog use of the codes belong to other blocks. The limit-reset pin is taken to be synchronous to `clk` already.

Top module: `chg_limit_regfile`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), parameter register n (addresses 0 to 5) reads {1'b0, n[2:0], (n+8)[3:0]}, the limit register (address 6) reads 0x00, the block is unlocked and `wr_ignored` is 0.
- R2: A write to addresses 0 to 5 stores `wr_data` at that clock edge. `rd_data` shows the register selected by `rd_addr` in the same cycle.
- R3: With the pin high and the block unlocked, a write to address 6 stores `wr_data`. Bits [7:4] are the current ceiling and bits [3:0] are the voltage ceiling.
- R4: A write to any of addresses 0 to 5 while the pin is high locks the block. Later writes to address 6 leave it unchanged.
- R5: At every clock edge where `limit_rst_n` is low, the limit register is forced to 0x00, writes to address 6 are dropped and the lock is cleared.
- R6: A dropped write to address 6 (block locked or pin low) sets `wr_ignored` to 1 for the next cycle only. Every other write leaves it at 0.
- R7: Writing address 0 with bit 7 set stores the word, so bit 7 reads 1 for one cycle. At the next edge all of addresses 0 to 5 reload their R1 defaults, which overrides any parameter write in that cycle. The limit register and the lock keep their values.
- R8: `ichg_eff` equals min(reg5[7:4], limit[7:4]) and `vreg_eff` equals min(reg2[3:0], limit[3:0]).
- R9: Address 7 always reads 0x00. A write to it changes nothing and does not lock the block.
- R10: Reads return the stored codes, not the clamped codes, even when a stored code is above its ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| limit_rst_n | input | 1 | Active-low pin that holds the ceilings at defaults and clears the lock |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Stored contents at `rd_addr` (combinational) |
| wr_ignored | output | 1 | One-cycle flag for a dropped ceiling write |
| ichg_eff | output | 4 | Charge-current code after clamping |
| vreg_eff | output | 4 | Regulation-voltage code after clamping |

## Verification
A wrong lock state shows up on the first later write to address 6. Either the read-back of address 6 changes when it should not, or `wr_ignored` disagrees one cycle after the write. A stuck or early soft-reset bit shows up within two cycles as a wrong bit 7 or wrong defaults on the read port. A bad ceiling shows on `ichg_eff` and `vreg_eff` in the cycle it is stored. The read port is swept over all eight addresses after every edge, so a corrupted register shows up within one cycle.

// File: rtl/chg_limit_pkg.sv
// Package: shared sizes, addresses and reset values for the charger
// limit register file. Assumes an 8-bit data word split into two
// equal code fields.
package chg_limit_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int FIELD_W    = DATA_W / 2;
    localparam int NUM_PARAM  = 6;
    localparam int CTRL_ADDR  = 0;
    localparam int SRST_BIT   = DATA_W - 1;
    localparam int VREG_ADDR  = 2;
    localparam int ICHG_ADDR  = 5;
    localparam int LIMIT_ADDR = 6;

    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [FIELD_W-1:0] code_t;

    // Ceilings reset to their lowest codes.
    localparam word_t LIMIT_DEFAULT = '0;

    // Reset value of parameter register idx: index in the upper field,
    // index plus eight in the lower field.
    function automatic word_t param_default(input int idx);
        int lower;
        lower = (idx + 8) % (1 << FIELD_W);
        return word_t'((idx << FIELD_W) | lower);
    endfunction
endpackage

// File: rtl/chg_param_bank.sv
// Module: parameter register bank with self-clearing soft reset.
// Holds NUM_PARAM words. A write to CTRL_ADDR with SRST_BIT set stores
// the word and raises a pending flag. At the next edge every word
// reloads its default, the flag clears and that cycle's write is lost.
// Assumes at most one write per cycle.
module chg_param_bank
    import chg_limit_pkg::*;
#(
    parameter int P_ADDR_W    = ADDR_W,
    parameter int P_DATA_W    = DATA_W,
    parameter int P_NUM_PARAM = NUM_PARAM,
    parameter int P_CTRL_ADDR = CTRL_ADDR,
    parameter int P_SRST_BIT  = SRST_BIT
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    wr_en,
    input  logic [P_ADDR_W-1:0]                     wr_addr,
    input  logic [P_DATA_W-1:0]                     wr_data,
    output logic [P_NUM_PARAM-1:0][P_DATA_W-1:0]    regs_o,
    output logic                                    srst_pend_o
);
    localparam logic [P_ADDR_W-1:0] CTRL_A = P_ADDR_W'(P_CTRL_ADDR);

    logic srst_req;
    logic srst_pend_q;

    // Detect a control write that requests a soft reset.
    always_comb begin
        srst_req = wr_en && (wr_addr == CTRL_A) && wr_data[P_SRST_BIT];
    end

    // Pending flag: set by the request, cleared one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_pend_q <= 1'b0;
        end else if (srst_pend_q) begin
            srst_pend_q <= 1'b0;
        end else begin
            srst_pend_q <= srst_req;
        end
    end

    assign srst_pend_o = srst_pend_q;

    // One storage word per parameter address.
    for (genvar g = 0; g < P_NUM_PARAM; g++) begin : g_word
        localparam logic [P_ADDR_W-1:0] MY_A = P_ADDR_W'(g);
        localparam logic [P_DATA_W-1:0] MY_DEF = P_DATA_W'(param_default(g));
        logic [P_DATA_W-1:0] word_q;

        // Reset and soft reset reload defaults, otherwise take writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= MY_DEF;
            end else if (srst_pend_q) begin
                word_q <= MY_DEF;
            end else if (wr_en && (wr_addr == MY_A)) begin
                word_q <= wr_data;
            end
        end

        assign regs_o[g] = word_q;
    end
endmodule

// File: rtl/chg_limit_guard.sv
// Module: safety ceiling register with its write lock.
// The lock sets on the first parameter write (addresses below
// P_NUM_PARAM) while the pin is high. The pin held low forces the
// ceilings to default and clears the lock. A dropped ceiling write
// pulses wr_ignored_o one cycle later. Assumes limit_rst_n is already
// synchronous to clk.
module chg_limit_guard
    import chg_limit_pkg::*;
#(
    parameter int P_ADDR_W     = ADDR_W,
    parameter int P_DATA_W     = DATA_W,
    parameter int P_NUM_PARAM  = NUM_PARAM,
    parameter int P_LIMIT_ADDR = LIMIT_ADDR
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 limit_rst_n,
    input  logic                 wr_en,
    input  logic [P_ADDR_W-1:0]  wr_addr,
    input  logic [P_DATA_W-1:0]  wr_data,
    output logic [P_DATA_W-1:0]  limit_o,
    output logic                 locked_o,
    output logic                 wr_ignored_o
);
    localparam logic [P_ADDR_W-1:0] LIM_A  = P_ADDR_W'(P_LIMIT_ADDR);
    localparam logic [P_ADDR_W-1:0] PARAM_N = P_ADDR_W'(P_NUM_PARAM);
    localparam logic [P_DATA_W-1:0] LIM_DEF = P_DATA_W'(LIMIT_DEFAULT);

    logic                lim_hit;
    logic                param_hit;
    logic                lock_q;
    logic                ign_q;
    logic [P_DATA_W-1:0] limit_q;

    // Decode which kind of register the current write targets.
    always_comb begin
        lim_hit   = wr_en && (wr_addr == LIM_A);
        param_hit = wr_en && (wr_addr < PARAM_N);
    end

    // Lock state: cleared by reset or a low pin, set by a parameter write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (!limit_rst_n) begin
            lock_q <= 1'b0;
        end else if (param_hit) begin
            lock_q <= 1'b1;
        end
    end

    // Ceiling storage: held at default by the pin, writable while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= LIM_DEF;
        end else if (!limit_rst_n) begin
            limit_q <= LIM_DEF;
        end else if (lim_hit && !lock_q) begin
            limit_q <= wr_data;
        end
    end

    // Dropped-write flag, one cycle after the offending write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ign_q <= 1'b0;
        end else begin
            ign_q <= lim_hit && (!limit_rst_n || lock_q);
        end
    end

    assign limit_o      = limit_q;
    assign locked_o     = lock_q;
    assign wr_ignored_o = ign_q;
endmodule

// File: rtl/chg_code_clamp.sv
// Module: passes the smaller of a programmed code and its ceiling.
// Purely combinational; both codes are unsigned.
module chg_code_clamp #(
    parameter int P_FIELD_W = chg_limit_pkg::FIELD_W
) (
    input  logic [P_FIELD_W-1:0] prog_code,
    input  logic [P_FIELD_W-1:0] ceil_code,
    output logic [P_FIELD_W-1:0] eff_code
);
    // Select the lower of the two codes.
    always_comb begin
        eff_code = (prog_code > ceil_code) ? ceil_code : prog_code;
    end
endmodule

// File: rtl/chg_limit_regfile.sv
// Module: top of the charger limit register file.
// Ties together the parameter bank, the ceiling guard, two clamps and a
// combinational read mux. Unmapped addresses read zero. Assumes one
// writer and a limit pin synchronous to clk.
module chg_limit_regfile
    import chg_limit_pkg::*;
#(
    parameter int P_ADDR_W     = ADDR_W,
    parameter int P_DATA_W     = DATA_W,
    parameter int P_NUM_PARAM  = NUM_PARAM,
    parameter int P_LIMIT_ADDR = LIMIT_ADDR,
    parameter int P_VREG_ADDR  = VREG_ADDR,
    parameter int P_ICHG_ADDR  = ICHG_ADDR
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    limit_rst_n,
    input  logic                    wr_en,
    input  logic [P_ADDR_W-1:0]     wr_addr,
    input  logic [P_DATA_W-1:0]     wr_data,
    input  logic [P_ADDR_W-1:0]     rd_addr,
    output logic [P_DATA_W-1:0]     rd_data,
    output logic                    wr_ignored,
    output logic [P_DATA_W/2-1:0]   ichg_eff,
    output logic [P_DATA_W/2-1:0]   vreg_eff
);
    localparam int HALF_W = P_DATA_W / 2;
    localparam logic [P_ADDR_W-1:0] LIM_A = P_ADDR_W'(P_LIMIT_ADDR);

    logic [P_NUM_PARAM-1:0][P_DATA_W-1:0] regs_w;
    logic                                 srst_pend_w;
    logic [P_DATA_W-1:0]                  limit_w;
    logic                                 locked_w;

    chg_param_bank #(
        .P_ADDR_W    (P_ADDR_W),
        .P_DATA_W    (P_DATA_W),
        .P_NUM_PARAM (P_NUM_PARAM),
        .P_CTRL_ADDR (CTRL_ADDR),
        .P_SRST_BIT  (P_DATA_W - 1)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .regs_o      (regs_w),
        .srst_pend_o (srst_pend_w)
    );

    chg_limit_guard #(
        .P_ADDR_W     (P_ADDR_W),
        .P_DATA_W     (P_DATA_W),
        .P_NUM_PARAM  (P_NUM_PARAM),
        .P_LIMIT_ADDR (P_LIMIT_ADDR)
    ) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .limit_rst_n  (limit_rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .limit_o      (limit_w),
        .locked_o     (locked_w),
        .wr_ignored_o (wr_ignored)
    );

    chg_code_clamp #(.P_FIELD_W(HALF_W)) u_clamp_ichg (
        .prog_code (regs_w[P_ICHG_ADDR][P_DATA_W-1:HALF_W]),
        .ceil_code (limit_w[P_DATA_W-1:HALF_W]),
        .eff_code  (ichg_eff)
    );

    chg_code_clamp #(.P_FIELD_W(HALF_W)) u_clamp_vreg (
        .prog_code (regs_w[P_VREG_ADDR][HALF_W-1:0]),
        .ceil_code (limit_w[HALF_W-1:0]),
        .eff_code  (vreg_eff)
    );

    // Read mux: stored contents, zero for unmapped addresses.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < P_NUM_PARAM; i++) begin
            if (rd_addr == P_ADDR_W'(i)) begin
                rd_data = regs_w[i];
            end
        end
        if (rd_addr == LIM_A) begin
            rd_data = limit_w;
        end
    end
endmodule

// File: rtl/chg_limit_regfile_chk.sv
// Module: assertion checker bound into chg_limit_regfile. Observes the
// ports and the internal ceiling, lock and soft-reset flag.
module chg_limit_regfile_chk
    import chg_limit_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                limit_rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [DATA_W-1:0]   rd_data,
    input logic                wr_ignored,
    input logic [FIELD_W-1:0]  ichg_eff,
    input logic [FIELD_W-1:0]  vreg_eff,
    input logic [DATA_W-1:0]   limit_q,
    input logic                locked,
    input logic                srst_pend
);
    // R5: a low pin leaves the ceilings at default after the edge.
    assert_pin_holds_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !limit_rst_n |=> (limit_q == LIMIT_DEFAULT));

    // R4: a locked ceiling does not move while the pin stays high.
    assert_locked_limit_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && limit_rst_n) |=> $stable(limit_q));

    // R4: a parameter write with the pin high locks the block.
    assert_param_write_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr < ADDR_W'(NUM_PARAM)) && limit_rst_n) |=> locked);

    // R6: a dropped ceiling write raises the flag one cycle later.
    assert_drop_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_W'(LIMIT_ADDR)) && (locked || !limit_rst_n)) |=> wr_ignored);

    // R7: the soft-reset request never lasts two cycles.
    assert_srst_self_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pend |=> !srst_pend);

    // R8: clamped codes never exceed their ceilings.
    assert_codes_within_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ichg_eff <= limit_q[DATA_W-1:FIELD_W]) && (vreg_eff <= limit_q[FIELD_W-1:0]));

    // R9: addresses above the ceiling register read zero.
    assert_reserved_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > ADDR_W'(LIMIT_ADDR)) |-> (rd_data == '0));
endmodule

bind chg_limit_regfile chg_limit_regfile_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .limit_rst_n (limit_rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wr_ignored  (wr_ignored),
    .ichg_eff    (ichg_eff),
    .vreg_eff    (vreg_eff),
    .limit_q     (limit_w),
    .locked      (locked_w),
    .srst_pend   (srst_pend_w)
);

// File: tb/test_chg_limit_regfile.sv
`timescale 1ns/100ps
module test_chg_limit_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       limit_rst_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wr_ignored;
    logic [3:0] ichg_eff;
    logic [3:0] vreg_eff;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // Reference state built from the requirements.
    logic [7:0] m_reg [6];
    logic [7:0] m_lim;
    logic       m_lock;
    logic       m_pend;
    logic       m_ign;

    always #2 clk = ~clk;

    chg_limit_regfile i_chg_limit_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .limit_rst_n (limit_rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .wr_ignored  (wr_ignored),
        .ichg_eff    (ichg_eff),
        .vreg_eff    (vreg_eff)
    );

    function automatic logic [7:0] dflt(input int n);
        logic [2:0] up = 3'(n);
        logic [3:0] lo = 4'(n + 8);
        return {1'b0, up, lo};
    endfunction

    function automatic logic [3:0] min4(input logic [3:0] a, input logic [3:0] b);
        return (a < b) ? a : b;
    endfunction

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    // Next state of the reference after one edge.
    task automatic model_step(input logic rn, input logic pin, input logic we,
                              input logic [2:0] a, input logic [7:0] d);
        logic [7:0] nreg [6];
        logic [7:0] nlim;
        logic       nlock;
        logic       npend;
        if (!rn) begin
            for (int i = 0; i < 6; i++) m_reg[i] = dflt(i);
            m_lim = 8'h00; m_lock = 1'b0; m_pend = 1'b0; m_ign = 1'b0;
            return;
        end
        for (int i = 0; i < 6; i++) nreg[i] = m_reg[i];
        nlim = m_lim; nlock = m_lock; npend = 1'b0;
        if (m_pend) begin
            for (int i = 0; i < 6; i++) nreg[i] = dflt(i);
        end else if (we && a < 3'd6) begin
            nreg[a] = d;
            if (a == 3'd0 && d[7]) npend = 1'b1;
        end
        if (!pin) begin
            nlock = 1'b0; nlim = 8'h00;
        end else begin
            if (we && a < 3'd6) nlock = 1'b1;
            if (we && a == 3'd6 && !m_lock) nlim = d;
        end
        m_ign = we && (a == 3'd6) && (!pin || m_lock);
        for (int i = 0; i < 6; i++) m_reg[i] = nreg[i];
        m_lim = nlim; m_lock = nlock; m_pend = npend;
    endtask

    task automatic check_all();
        for (int i = 0; i < 8; i++) begin
            logic [7:0] exp;
            string      tag;
            rd_addr = 3'(i);
            #0.1;
            if (i < 6) begin exp = m_reg[i]; tag = "R2 param read"; end
            else if (i == 6) begin exp = m_lim; tag = "R3 limit read"; end
            else begin exp = 8'h00; tag = "R9 reserved read"; end
            check($sformatf("%s a=%0d", tag, i), rd_data, exp);
        end
        check("R8 ichg_eff", {4'h0, ichg_eff}, {4'h0, min4(m_reg[5][7:4], m_lim[7:4])});
        check("R8 vreg_eff", {4'h0, vreg_eff}, {4'h0, min4(m_reg[2][3:0], m_lim[3:0])});
        check("R6 wr_ignored", {7'h0, wr_ignored}, {7'h0, m_ign});
    endtask

    task automatic cycle(input logic rn, input logic pin, input logic we,
                         input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        rst_n = rn; limit_rst_n = pin; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step(rn, pin, we, a, d);
        #0.5;
        check_all();
    endtask

    task automatic idle();
        cycle(1'b1, 1'b1, 1'b0, 3'd0, 8'h00);
    endtask

    initial begin
        void'($urandom(32'h5A17_C0DE));
        // R1: reset state.
        phase = "R1";
        repeat (3) cycle(1'b0, 1'b1, 1'b0, 3'd0, 8'h00);
        idle();

        // R3: ceiling written while unlocked.
        phase = "R3";
        cycle(1'b1, 1'b1, 1'b1, 3'd6, 8'hA7);
        check("R3 direct limit", rd_data, 8'h00); // rd_addr left at 7 (R9)
        rd_addr = 3'd6; #0.1;
        check("R3 direct limit a=6", rd_data, 8'hA7);

        // R10: stored code above its ceiling reads unclamped; this write locks.
        phase = "R10";
        cycle(1'b1, 1'b1, 1'b1, 3'd2, 8'h0F);
        rd_addr = 3'd2; #0.1;
        check("R10 unclamped read", rd_data, 8'h0F);
        check("R10 clamped vreg", {4'h0, vreg_eff}, 8'h07);
        cycle(1'b1, 1'b1, 1'b1, 3'd5, 8'h30);

        // R4: locked ceiling ignores a write, flag pulses once.
        phase = "R4";
        cycle(1'b1, 1'b1, 1'b1, 3'd6, 8'hFF);
        check("R4 flag after drop", {7'h0, wr_ignored}, 8'h01);
        idle();
        check("R4 flag single cycle", {7'h0, wr_ignored}, 8'h00);

        // R5: pin low forces default, drops writes, then reopens the window.
        phase = "R5";
        cycle(1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
        cycle(1'b1, 1'b0, 1'b1, 3'd6, 8'h99);
        check("R5 drop while pin low", {7'h0, wr_ignored}, 8'h01);

        // R9: reserved write neither stores nor locks.
        phase = "R9";
        cycle(1'b1, 1'b1, 1'b1, 3'd7, 8'h55);
        cycle(1'b1, 1'b1, 1'b1, 3'd6, 8'h5C);
        rd_addr = 3'd6; #0.1;
        check("R9 no lock from reserved write", rd_data, 8'h5C);

        // R7: soft reset, with a parameter write in the reload cycle.
        phase = "R7";
        cycle(1'b1, 1'b1, 1'b1, 3'd3, 8'hEE);
        cycle(1'b1, 1'b1, 1'b1, 3'd0, 8'h91);
        rd_addr = 3'd0; #0.1;
        check("R7 bit reads set", rd_data, 8'h91);
        cycle(1'b1, 1'b1, 1'b1, 3'd4, 8'h77);
        rd_addr = 3'd4; #0.1;
        check("R7 defaults win", rd_data, dflt(4));
        rd_addr = 3'd6; #0.1;
        check("R7 limit kept", rd_data, 8'h5C);
        idle();

        // Random traffic.
        phase = "random";
        for (int k = 0; k < 600; k++) begin
            logic       rn = ($urandom % 80) != 0;
            logic       pin = ($urandom % 10) != 0;
            logic       we = ($urandom % 4) != 0;
            logic [2:0] a = 3'($urandom % 8);
            logic [7:0] d = 8'($urandom);
            cycle(rn, pin, we, a, d);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule